// File: doc/BRIEF.md
# Character FIFO Pair with Threshold Interrupts

This block buffers smart card characters in two eight-entry queues, one holding characters waiting to go out to the card and one holding characters the receiver has collected. Each queue has a programmable threshold. The receive interrupt tells software that enough characters have arrived. The transmit interrupt tells software that the outgoing queue has drained far enough to take more. A direction bit selects whether the session is sending or receiving. Software can write to the outgoing queue only while sending. The receive interrupt is live only while receiving. The transmit interrupt follows the fill level in both directions, so software hears about free space as early as possible.

The transmitter reads the oldest outgoing character without removing it. A small handshake state machine offers that character and then waits for the outcome. A success pulse removes the character. A retry pulse leaves it at the head so that it is sent again. After either outcome the offer drops for one cycle, so each new offer starts with a clean rising edge.

The handshake controller has three states. TXS_IDLE means the outgoing queue is empty. TXS_OFFER means the head character is presented on `tx_data` with `tx_valid` high. TXS_GAP is a one-cycle pause after an outcome. The transitions are:
- TXS_IDLE to TXS_OFFER when the queue holds data.
- TXS_OFFER to TXS_GAP on a success or retry pulse.
- TXS_GAP to TXS_OFFER if data remains.
- TXS_GAP to TXS_IDLE if the queue is empty.

Top module: `fifo_tide_irq`

## Requirements
- R1: After reset both queues are empty, the direction bit is 0 (receive), both thresholds are 0, both overflow flags are clear and `tx_valid` is low; register reads return 0 at addresses 0, 1 and 3.
- R2: Address 1 holds the receive threshold in bits 7:4 and the transmit threshold in bits 3:0, and reads back exactly as written; for the comparison, a threshold above 8 behaves as 8.
- R3: While the direction bit is 0, `irq_rx` is high exactly when the receive count is greater than or equal to the receive threshold. A threshold of 1 fires as soon as the queue holds a character.
- R4: While the direction bit (address 0, bit 0) is 1, `irq_rx` stays low whatever the receive count.
- R5: `irq_tx` is high exactly when the transmit count is less than or equal to the transmit threshold, in either direction.
- R6: A write of a character to address 2 enters the transmit queue only while the direction bit is 1; otherwise the transmit count is unchanged.
- R7: Characters leave each queue in arrival order. Reading address 2 returns the oldest receive character one cycle after the read strobe and removes it.
- R8: The head transmit character stays on `tx_data` until a success pulse; after a retry pulse the same character is offered again.
- R9: After a success or retry pulse while `tx_valid` is high, `tx_valid` is low for exactly one cycle and then high again if data remains. Success and retry pulses while `tx_valid` is low have no effect.
- R10: A character written to a full transmit queue or pushed into a full receive queue is dropped, and sets a sticky flag. The flags are status bit 15 (transmit) and bit 14 (receive); writing 1 to that bit at address 3 clears it. Status bits 7:4 give the receive count and bits 3:0 the transmit count.
- R11: Reading address 2 while the receive queue is empty returns 0 and changes no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 direction, 1 thresholds, 2 transmit character, 3 flag clear |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address: 0 direction, 1 thresholds, 2 receive character, 3 status |
| rd_data | output | 16 | Read data, registered on the read strobe |
| rx_push | input | 1 | Receiver delivers a character |
| rx_char | input | 8 | Character from the receiver |
| tx_valid | output | 1 | Head transmit character is offered |
| tx_data | output | 8 | Head transmit character |
| tx_done | input | 1 | Offered character was sent successfully |
| tx_retry | input | 1 | Offered character must be resent |
| irq_rx | output | 1 | Receive threshold interrupt, level |
| irq_tx | output | 1 | Transmit threshold interrupt, level |

## Verification
A wrong fill count shows at the interrupt pins in the cycle right after the bad update, because both levels are compared with the live counts. It also shows in the status word on the next read. A corrupted read or write pointer shows as an out-of-order character, either on the next receive read or on `tx_data` at the next offer. A handshake controller in the wrong state shows within two cycles, as an offer that never returns, an offer without data, or a head that moves on a retry.

// File: rtl/tide_pkg.sv
`timescale 1ns/1ps
package tide_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_TIDE = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_STAT = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        TXS_IDLE  = 2'd0,
        TXS_OFFER = 2'd1,
        TXS_GAP   = 2'd2
    } tx_state_e;

endpackage

// File: rtl/tide_fifo.sv
`timescale 1ns/1ps
// Synchronous queue whose oldest entry is visible without being removed.
module tide_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wp_q;
    logic [PW-1:0] rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push;
    logic          do_pop;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[wp_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wp_q <= step_ptr(wp_q);
            end
            if (do_pop) begin
                rp_q <= step_ptr(rp_q);
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem_q[rp_q];
    assign count = cnt_q;

endmodule

// File: rtl/tide_level.sv
`timescale 1ns/1ps
// Threshold comparator; AT_LEAST picks "count >= level" or "count <= level".
module tide_level #(
    parameter int DEPTH    = 8,
    parameter int CW       = 4,
    parameter int TW       = 4,
    parameter bit AT_LEAST = 1'b1
) (
    input  logic [CW-1:0] count,
    input  logic [TW-1:0] tide,
    input  logic          enable,
    output logic          hit
);

    logic [31:0] lim;
    logic [31:0] cnt32;

    always_comb begin
        if (32'(tide) > 32'(DEPTH)) begin
            lim = 32'(DEPTH);
        end else begin
            lim = 32'(tide);
        end
    end

    assign cnt32 = 32'(count);

    generate
        if (AT_LEAST) begin : g_at_least
            assign hit = enable && (cnt32 >= lim);
        end else begin : g_at_most
            assign hit = enable && (cnt32 <= lim);
        end
    endgenerate

endmodule

// File: rtl/tide_tx_ctrl.sv
`timescale 1ns/1ps
// Offer / outcome handshake towards the character transmitter.
module tide_tx_ctrl
    import tide_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic have_data,
    input  logic done,
    input  logic retry,
    output logic offer,
    output logic pop
);

    tx_state_e st_q;
    tx_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TXS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TXS_IDLE: begin
                if (have_data) begin
                    st_d = TXS_OFFER;
                end
            end
            TXS_OFFER: begin
                if (done || retry) begin
                    st_d = TXS_GAP;
                end
            end
            TXS_GAP: begin
                st_d = have_data ? TXS_OFFER : TXS_IDLE;
            end
            default: st_d = TXS_IDLE;
        endcase
    end

    always_comb begin
        offer = (st_q == TXS_OFFER);
        pop   = (st_q == TXS_OFFER) && done;
    end

endmodule

// File: rtl/tide_cfg.sv
`timescale 1ns/1ps
// Direction, thresholds, sticky drop flags and the registered read path.
module tide_cfg
    import tide_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int CHAR_W = 8,
    parameter int TW     = 4,
    parameter int CW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    input  logic [CHAR_W-1:0] rx_head,
    input  logic              rx_empty,
    input  logic [CW-1:0]     rx_cnt,
    input  logic [CW-1:0]     tx_cnt,
    input  logic              tx_drop,
    input  logic              rx_drop,
    output logic              dir,
    output logic [TW-1:0]     rx_tide,
    output logic [TW-1:0]     tx_tide,
    output logic              tx_wr_req,
    output logic              rx_rd,
    output logic              tx_ovf,
    output logic              rx_ovf,
    output logic [REG_W-1:0]  rd_data
);

    logic             dir_q;
    logic [TW-1:0]    rx_tide_q;
    logic [TW-1:0]    tx_tide_q;
    logic             tx_ovf_q;
    logic             rx_ovf_q;
    logic [REG_W-1:0] rd_q;
    logic [REG_W-1:0] rd_mux;
    logic             wr_ctrl;
    logic             wr_tide;
    logic             wr_stat;
    logic             unused_wr;

    assign unused_wr = ^wr_data;
    assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_tide   = wr_en && (wr_addr == ADDR_TIDE);
    assign wr_stat   = wr_en && (wr_addr == ADDR_STAT);
    assign tx_wr_req = wr_en && (wr_addr == ADDR_DATA) && dir_q;
    assign rx_rd     = rd_en && (rd_addr == ADDR_DATA) && !rx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= 1'b0;
            rx_tide_q <= '0;
            tx_tide_q <= '0;
        end else begin
            if (wr_ctrl) begin
                dir_q <= wr_data[0];
            end
            if (wr_tide) begin
                rx_tide_q <= wr_data[2*TW-1:TW];
                tx_tide_q <= wr_data[TW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ovf_q <= 1'b0;
            rx_ovf_q <= 1'b0;
        end else begin
            if (tx_drop) begin
                tx_ovf_q <= 1'b1;
            end else if (wr_stat && wr_data[REG_W-1]) begin
                tx_ovf_q <= 1'b0;
            end
            if (rx_drop) begin
                rx_ovf_q <= 1'b1;
            end else if (wr_stat && wr_data[REG_W-2]) begin
                rx_ovf_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (reg_addr_e'(rd_addr))
            ADDR_CTRL: rd_mux[0] = dir_q;
            ADDR_TIDE: rd_mux[2*TW-1:0] = {rx_tide_q, tx_tide_q};
            ADDR_DATA: rd_mux = rx_empty ? '0 : REG_W'(rx_head);
            ADDR_STAT: begin
                rd_mux[REG_W-1]     = tx_ovf_q;
                rd_mux[REG_W-2]     = rx_ovf_q;
                rd_mux[2*CW-1:CW]   = rx_cnt;
                rd_mux[CW-1:0]      = tx_cnt;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_mux;
        end
    end

    assign dir     = dir_q;
    assign rx_tide = rx_tide_q;
    assign tx_tide = tx_tide_q;
    assign tx_ovf  = tx_ovf_q;
    assign rx_ovf  = rx_ovf_q;
    assign rd_data = rd_q;

endmodule

// File: rtl/fifo_tide_irq.sv
`timescale 1ns/1ps
// Transmit and receive character queues with threshold interrupts.
module fifo_tide_irq #(
    parameter int DEPTH  = 8,
    parameter int CHAR_W = 8,
    parameter int REG_W  = 16,
    parameter int TW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              rx_push,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_done,
    input  logic              tx_retry,
    output logic              irq_rx,
    output logic              irq_tx
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              dir_q;
    logic [TW-1:0]     rx_tide;
    logic [TW-1:0]     tx_tide;
    logic              tx_wr_req;
    logic              tx_push;
    logic              tx_drop;
    logic              tx_pop;
    logic              tx_full;
    logic              tx_empty;
    logic [CNT_W-1:0]  tx_cnt;
    logic              rx_rd;
    logic              rx_drop;
    logic              rx_full;
    logic              rx_empty;
    logic [CNT_W-1:0]  rx_cnt;
    logic [CHAR_W-1:0] rx_head;
    logic              tx_ovf;
    logic              rx_ovf;

    assign tx_push = tx_wr_req && !tx_full;
    assign tx_drop = tx_wr_req && tx_full;
    assign rx_drop = rx_push && rx_full;

    tide_cfg #(
        .REG_W (REG_W),
        .CHAR_W(CHAR_W),
        .TW    (TW),
        .CW    (CNT_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rx_head  (rx_head),
        .rx_empty (rx_empty),
        .rx_cnt   (rx_cnt),
        .tx_cnt   (tx_cnt),
        .tx_drop  (tx_drop),
        .rx_drop  (rx_drop),
        .dir      (dir_q),
        .rx_tide  (rx_tide),
        .tx_tide  (tx_tide),
        .tx_wr_req(tx_wr_req),
        .rx_rd    (rx_rd),
        .tx_ovf   (tx_ovf),
        .rx_ovf   (rx_ovf),
        .rd_data  (rd_data)
    );

    tide_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_tx_q (
        .clk  (clk),
        .rst_n(rst_n),
        .push (tx_push),
        .din  (wr_data[CHAR_W-1:0]),
        .pop  (tx_pop),
        .head (tx_data),
        .count(tx_cnt),
        .full (tx_full),
        .empty(tx_empty)
    );

    tide_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_rx_q (
        .clk  (clk),
        .rst_n(rst_n),
        .push (rx_push),
        .din  (rx_char),
        .pop  (rx_rd),
        .head (rx_head),
        .count(rx_cnt),
        .full (rx_full),
        .empty(rx_empty)
    );

    tide_tx_ctrl u_txc (
        .clk      (clk),
        .rst_n    (rst_n),
        .have_data(!tx_empty),
        .done     (tx_done),
        .retry    (tx_retry),
        .offer    (tx_valid),
        .pop      (tx_pop)
    );

    tide_level #(.DEPTH(DEPTH), .CW(CNT_W), .TW(TW), .AT_LEAST(1'b1)) u_rx_lvl (
        .count (rx_cnt),
        .tide  (rx_tide),
        .enable(!dir_q),
        .hit   (irq_rx)
    );

    tide_level #(.DEPTH(DEPTH), .CW(CNT_W), .TW(TW), .AT_LEAST(1'b0)) u_tx_lvl (
        .count (tx_cnt),
        .tide  (tx_tide),
        .enable(1'b1),
        .hit   (irq_tx)
    );

endmodule

// File: rtl/tide_irq_chk.sv
`timescale 1ns/1ps
module tide_irq_chk #(
    parameter int DEPTH  = 8,
    parameter int CW     = 4,
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dir,
    input logic [CW-1:0]     tx_cnt,
    input logic [CW-1:0]     rx_cnt,
    input logic              irq_rx,
    input logic              irq_tx,
    input logic              tx_valid,
    input logic [CHAR_W-1:0] tx_data,
    input logic              tx_done,
    input logic              tx_retry,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic              rx_push,
    input logic              rx_full,
    input logic              rx_ovf
);

    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dir |-> !irq_rx); // R4

    AST_RX_FULL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir && rx_cnt == CW'(DEPTH)) |-> irq_rx); // R3

    AST_TX_EMPTY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == '0) |-> irq_tx); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH))); // R10

    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> rx_ovf); // R10

    AST_RETRY_HOLDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_retry && !tx_done) |=> $stable(tx_data)); // R8

    AST_OUTCOME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && (tx_done || tx_retry)) |=> !tx_valid); // R9

    AST_TX_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && !dir && !(tx_valid && tx_done))
        |=> (tx_cnt == $past(tx_cnt))); // R6

endmodule

bind fifo_tide_irq tide_irq_chk #(
    .DEPTH (DEPTH),
    .CW    (CNT_W),
    .CHAR_W(CHAR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir     (dir_q),
    .tx_cnt  (tx_cnt),
    .rx_cnt  (rx_cnt),
    .irq_rx  (irq_rx),
    .irq_tx  (irq_tx),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .tx_done (tx_done),
    .tx_retry(tx_retry),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rx_push (rx_push),
    .rx_full (rx_full),
    .rx_ovf  (rx_ovf)
);

// File: tb/tb_fifo_tide_irq.sv
`timescale 1ns/1ps
module tb_fifo_tide_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_done = 1'b0;
    logic        tx_retry = 1'b0;
    logic        irq_rx;
    logic        irq_tx;

    int n_checks = 0;
    int n_fail = 0;
    bit reported = 1'b0;

    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    logic       dir_m;
    logic [7:0] tide_m;

    always #5 clk = ~clk;

    fifo_tide_irq dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rx_push(rx_push), .rx_char(rx_char),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_done(tx_done), .tx_retry(tx_retry),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    function automatic int lim(input logic [3:0] t);
        return (int'(t) > 8) ? 8 : int'(t);
    endfunction

    function automatic logic exp_irq_rx(input logic d, input logic [7:0] t, input int n);
        return !d && (n >= lim(t[7:4]));
    endfunction

    function automatic logic exp_irq_tx(input logic [7:0] t, input int n);
        return n <= lim(t[3:0]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; rx_push = 1'b0; tx_done = 1'b0; tx_retry = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [15:0] d);
        rd_en = 1'b1; rd_addr = a;
        step();
        d = rd_data;
    endtask

    task automatic push(input logic [7:0] c);
        rx_push = 1'b1; rx_char = c;
        step();
    endtask

    task automatic wait_offer();
        for (int i = 0; i < 4 && !tx_valid; i++) step();
    endtask

    initial begin
        #(10 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rdreg(2'd3, v); chk("R1 status", v, 16'h0000);
        rdreg(2'd0, v); chk("R1 ctrl", v, 16'h0000);
        rdreg(2'd1, v); chk("R1 tide", v, 16'h0000);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 irq_tx", irq_tx, 1);
        chk("R1 irq_rx", irq_rx, 1);

        // R2 fields and clamp
        wr(2'd1, 16'h00F5);
        rdreg(2'd1, v); chk("R2 readback", v, 16'h00F5);
        chk("R2 irq_rx empty", irq_rx, 0);
        for (int i = 0; i < 7; i++) push(8'h10 + 8'(i));
        chk("R2 irq_rx at 7", irq_rx, 0);
        push(8'h17);
        chk("R2 irq_rx clamp at 8", irq_rx, 1);
        chk("R5 irq_tx tide 5", irq_tx, 1);

        // R7 order, R3 level one
        wr(2'd1, 16'h0010);
        for (int i = 0; i < 8; i++) begin
            rdreg(2'd2, v); chk("R7 rx order", v, 16'h0010 + 16'(i));
        end
        chk("R3 irq_rx empty tide1", irq_rx, 0);
        rdreg(2'd2, v); chk("R11 empty read", v, 16'h0000);
        rdreg(2'd3, v); chk("R11 counts", v, 16'h0000);
        push(8'h55);
        chk("R3 irq_rx one char", irq_rx, 1);

        // R4 direction gates receive interrupt
        wr(2'd0, 16'h0001);
        chk("R4 irq_rx in transmit", irq_rx, 0);
        rdreg(2'd2, v); chk("R7 read in transmit", v, 16'h0055);

        // R10 receive overflow
        for (int i = 0; i < 9; i++) push(8'h20 + 8'(i));
        rdreg(2'd3, v); chk("R10 rx flag", v, 16'h4080);
        wr(2'd3, 16'h4000);
        rdreg(2'd3, v); chk("R10 rx flag clear", v, 16'h0080);
        for (int i = 0; i < 8; i++) begin
            rdreg(2'd2, v); chk("R10 rx kept", v, 16'h0020 + 16'(i));
        end
        rdreg(2'd2, v); chk("R10 ninth dropped", v, 16'h0000);

        // R6 write gating
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h00AA);
        rdreg(2'd3, v); chk("R6 tx write ignored", v, 16'h0000);
        wr(2'd0, 16'h0001);
        wr(2'd2, 16'h00A1);
        wr(2'd2, 16'h00A2);
        wr(2'd2, 16'h00A3);
        rdreg(2'd3, v); chk("R6 tx count", v, 16'h0003);
        wr(2'd1, 16'h0002);
        chk("R5 irq_tx above", irq_tx, 0);
        wr(2'd0, 16'h0000);

        // R8 R9 handshake
        wait_offer();
        chk("R8 first offer", {tx_valid, tx_data}, {1'b1, 8'hA1});
        tx_retry = 1'b1; step();
        chk("R9 gap after retry", tx_valid, 0);
        step();
        chk("R8 reoffer after retry", {tx_valid, tx_data}, {1'b1, 8'hA1});
        chk("R5 irq_tx still 3", irq_tx, 0);
        tx_done = 1'b1; step();
        chk("R9 gap after done", tx_valid, 0);
        chk("R5 irq_tx receive dir", irq_tx, 1);
        tx_done = 1'b1; step();
        chk("R9 done in gap ignored", {tx_valid, tx_data}, {1'b1, 8'hA2});
        rdreg(2'd3, v); chk("R9 count after gap done", v, 16'h0002);

        // R10 transmit overflow and drain
        wr(2'd0, 16'h0001);
        for (int i = 0; i < 7; i++) wr(2'd2, 16'h00B0 + 16'(i));
        rdreg(2'd3, v); chk("R10 tx flag", v, 16'h8008);
        wr(2'd3, 16'h8000);
        rdreg(2'd3, v); chk("R10 tx flag clear", v, 16'h0008);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] e;
            e = (i == 0) ? 8'hA2 : (i == 1) ? 8'hA3 : 8'hB0 + 8'(i - 2);
            wait_offer();
            chk("R7 tx order", {tx_valid, tx_data}, {1'b1, e});
            tx_done = 1'b1; step();
        end
        step(); step(); step();
        chk("R10 tx drained", tx_valid, 0);

        // Random phase
        void'($urandom(32'h5A17));
        dir_m = 1'b1;
        tide_m = 8'h02;
        for (int it = 0; it < 3000; it++) begin
            int r;
            int rx_pre;
            int tx_pre;
            logic [7:0] exp_rd;
            logic do_rd;
            logic do_txw;
            logic do_pop;
            rx_pre = rxq.size();
            tx_pre = txq.size();
            r = int'($urandom % 16);
            do_txw = 1'b0;
            if (r < 2) begin
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'($urandom % 2);
            end else if (r < 4) begin
                wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'($urandom % 256);
            end else if (r < 9) begin
                wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'($urandom % 256);
                do_txw = dir_m && (tx_pre < 8);
            end
            do_rd = ($urandom % 4) == 0;
            rd_en = do_rd; rd_addr = 2'd2;
            rx_push = ($urandom % 3) == 0;
            rx_char = 8'($urandom);
            exp_rd = (rx_pre > 0) ? rxq[0] : 8'h00;
            do_pop = 1'b0;
            if (tx_valid) begin
                if (tx_pre == 0) chk("R8 offer without data", 1, 0);
                else chk("R8 random head", tx_data, txq[0]);
                tx_done = ($urandom % 3) == 0;
                tx_retry = !tx_done && (($urandom % 4) == 0);
                do_pop = tx_done;
            end
            begin
                logic [7:0] wc;
                logic [1:0] wa;
                logic       we;
                logic       pu;
                logic [7:0] pc;
                wc = wr_data[7:0]; wa = wr_addr; we = wr_en; pu = rx_push; pc = rx_char;
                step();
                if (do_rd && rx_pre > 0) void'(rxq.pop_front());
                if (pu && rx_pre < 8) rxq.push_back(pc);
                if (do_pop) void'(txq.pop_front());
                if (do_txw) txq.push_back(wc);
                if (we && wa == 2'd0) dir_m = wc[0];
                if (we && wa == 2'd1) tide_m = wc;
            end
            if (do_rd) chk("R7 random read", rd_data, {8'h00, exp_rd});
            chk("R3 random irq_rx", irq_rx, exp_irq_rx(dir_m, tide_m, rxq.size()));
            chk("R5 random irq_tx", irq_tx, exp_irq_tx(tide_m, txq.size()));
        end

        report();
        $finish;
    end

endmodule